// File: doc/BRIEF.md
# Reorder Buffer with Multi-Cycle Squash Walk

This block keeps in-flight instruction records (PC, next PC, sequence number) in program order inside a circular buffer of `DEPTH` slots. New records enter at the tail. The oldest record leaves at the head, and only once it has been marked complete. A completion mark arrives by slot index, which the block hands out at allocation time on `alloc_idx_o`.

A misprediction does not clear the buffer in one cycle. A squash request stores a target sequence number and lowers `squash_done_o`. From the next cycle on, a walker moves from the tail toward the head and handles at most `SQ_W` slots per cycle. Each slot it passes is flagged squashed and flagged complete. These slots therefore stay in place and drain out through ordinary retirement.

The walk ends when it reaches one of three points:
- the slot that holds the target sequence number, which it leaves untouched;
- the head slot, after flagging it;
- a slot that has already retired.

While the walk runs, allocation is held off. Retirement continues.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `free_cnt_o` = DEPTH, `full_o` = 0, `head_ready_o` = 0, `squash_done_o` = 1.
- R2: An accepted allocation writes the slot at `alloc_idx_o` and makes it the new tail. `tail_pc_o`/`tail_seq_o` show the youngest record, and `head_pc_o`/`head_npc_o`/`head_seq_o` show the oldest. When the occupancy equals DEPTH, `full_o` is 1 and further allocations are ignored.
- R3: `free_cnt_o` always equals DEPTH minus the occupancy.
- R4: `retire_i` removes only the head record, and only when `head_ready_o` is 1. Otherwise it has no effect. Each retirement lowers the occupancy by one.
- R5: `head_ready_o` is 0 whenever the buffer is empty.
- R6: A squash request on a non-empty buffer with `squash_done_o` = 1 drives `squash_done_o` to 0 after that edge. Starting at the following edge, the walker handles up to SQ_W slots per cycle from the tail toward the head. Each handled slot shows `head_squashed_o` = 1 and `head_ready_o` = 1 once it reaches the head. A request on an empty buffer is ignored.
- R7: The walk ends, and `squash_done_o` returns to 1, at the edge where the walker lands on the slot holding the target sequence number. That slot is neither squashed nor marked complete. With n younger records, this takes max(1, ceil(n/SQ_W)) edges after the request edge.
- R8: If no slot holds the target, the walk flags the head slot, ends there and sets `squash_done_o`.
- R9: Allocation is ignored in the request cycle and for as long as `squash_done_o` is 0. Retirement still works during the walk. A slot that retires before the walker reaches it ends the walk.
- R10: `cmpl_i` with `cmpl_idx_i` marks that valid slot complete. Once it is the head, `head_ready_o` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocation request |
| alloc_pc_i | input | PC_W | PC of the new record |
| alloc_npc_i | input | PC_W | Next PC of the new record |
| alloc_seq_i | input | SEQ_W | Sequence number of the new record |
| alloc_idx_o | output | IDX_W | Slot the next allocation will take |
| full_o | output | 1 | Occupancy equals DEPTH |
| cmpl_i | input | 1 | Completion mark strobe |
| cmpl_idx_i | input | IDX_W | Slot to mark complete |
| retire_i | input | 1 | Retire head if ready |
| squash_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Target sequence number (kept) |
| squash_done_o | output | 1 | No walk in progress |
| free_cnt_o | output | CNT_W | Free slot count |
| head_ready_o | output | 1 | Head present and complete |
| head_squashed_o | output | 1 | Head record is squashed |
| head_pc_o | output | PC_W | Head PC |
| head_npc_o | output | PC_W | Head next PC |
| head_seq_o | output | SEQ_W | Head sequence number |
| tail_pc_o | output | PC_W | Tail PC |
| tail_seq_o | output | SEQ_W | Tail sequence number |

## Verification
The bench fills the buffer so that it wraps, then squashes five records with SQ_W = 2. A walker that skipped the post-step target check would take an extra cycle or squash the target. A walker that missed the head stop would wrap past the oldest record and never finish. One run retires the head during the walk; a walker without the retired-slot stop would loop over dead slots. Other runs try an allocation while the buffer is full, an allocation during a walk, and a retire while the head is not ready; a missing gate on any of these would show up as a moved tail or a wrong free count.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  typedef enum logic {WALK_IDLE, WALK_BUSY} walk_st_e;
endpackage

// File: rtl/rob_store.sv
`timescale 1ns/1ps
module rob_store #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        alloc_we_i,
  input  logic [IDX_W-1:0]            alloc_idx_i,
  input  logic [PC_W-1:0]             alloc_pc_i,
  input  logic [PC_W-1:0]             alloc_npc_i,
  input  logic [SEQ_W-1:0]            alloc_seq_i,
  input  logic                        cmpl_we_i,
  input  logic [IDX_W-1:0]            cmpl_idx_i,
  input  logic                        ret_we_i,
  input  logic [IDX_W-1:0]            ret_idx_i,
  input  logic [DEPTH-1:0]            mark_i,
  output logic [DEPTH-1:0]            valid_o,
  output logic [DEPTH-1:0]            ready_o,
  output logic [DEPTH-1:0]            squashed_o,
  output logic [DEPTH-1:0][PC_W-1:0]  pc_o,
  output logic [DEPTH-1:0][PC_W-1:0]  npc_o,
  output logic [DEPTH-1:0][SEQ_W-1:0] seq_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_alloc, hit_ret, hit_cmpl;
    assign hit_alloc = alloc_we_i && (alloc_idx_i == IDX_W'(i));
    assign hit_ret   = ret_we_i   && (ret_idx_i   == IDX_W'(i));
    assign hit_cmpl  = cmpl_we_i  && (cmpl_idx_i  == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i]    <= 1'b0;
        ready_o[i]    <= 1'b0;
        squashed_o[i] <= 1'b0;
        pc_o[i]       <= '0;
        npc_o[i]      <= '0;
        seq_o[i]      <= '0;
      end else if (hit_alloc) begin
        valid_o[i]    <= 1'b1;
        ready_o[i]    <= 1'b0;
        squashed_o[i] <= 1'b0;
        pc_o[i]       <= alloc_pc_i;
        npc_o[i]      <= alloc_npc_i;
        seq_o[i]      <= alloc_seq_i;
      end else begin
        if (hit_ret) valid_o[i] <= 1'b0;
        if (hit_cmpl && valid_o[i]) ready_o[i] <= 1'b1;
        if (mark_i[i]) begin
          squashed_o[i] <= 1'b1;
          ready_o[i]    <= 1'b1;
        end
      end
    end

    // R2
    alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_alloc |-> !valid_o[i]);
  end
endmodule

// File: rtl/rob_ptr_ctrl.sv
`timescale 1ns/1ps
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic             retire_fire_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] wr_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);
  logic [IDX_W-1:0] head_q, wr_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      wr_q    <= '0;
      count_q <= '0;
    end else begin
      if (alloc_fire_i)  wr_q   <= wr_q + 1'b1;
      if (retire_fire_i) head_q <= head_q + 1'b1;
      case ({alloc_fire_i, retire_fire_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign wr_o    = wr_q;
  assign tail_o  = wr_q - 1'b1;
  assign count_o = count_q;

  // R2
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R4
  retire_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_fire_i && !alloc_fire_i) |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/rob_squash_walk.sv
`timescale 1ns/1ps
module rob_squash_walk
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SQ_W  = 2,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [SEQ_W-1:0]            tgt_i,
  input  logic [IDX_W-1:0]            tail_i,
  input  logic [IDX_W-1:0]            head_i,
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
  output logic [DEPTH-1:0]            mark_o,
  output logic                        done_o
);
  walk_st_e         st_q;
  logic [IDX_W-1:0] ptr_q, ptr_nxt;
  logic [SEQ_W-1:0] tgt_q;
  logic             fin;

  // Unrolled walk: stop on target, on a retired slot, or after flagging head
  always_comb begin
    ptr_nxt = ptr_q;
    fin     = 1'b0;
    mark_o  = '0;
    if (st_q == WALK_BUSY) begin
      for (int k = 0; k < SQ_W; k++) begin
        if (!fin) begin
          if (!valid_i[ptr_nxt] || seq_i[ptr_nxt] == tgt_q) begin
            fin = 1'b1;
          end else begin
            mark_o[ptr_nxt] = 1'b1;
            if (ptr_nxt == head_i) fin = 1'b1;
            else ptr_nxt = ptr_nxt - 1'b1;
          end
        end
      end
      if (!fin && (!valid_i[ptr_nxt] || seq_i[ptr_nxt] == tgt_q)) fin = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WALK_IDLE;
      ptr_q <= '0;
      tgt_q <= '0;
    end else if (start_i) begin
      st_q  <= WALK_BUSY;
      ptr_q <= tail_i;
      tgt_q <= tgt_i;
    end else if (st_q == WALK_BUSY) begin
      ptr_q <= ptr_nxt;
      if (fin) st_q <= WALK_IDLE;
    end
  end

  assign done_o = (st_q == WALK_IDLE);

  // R6
  walk_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
  // R6
  mark_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mark_o) <= SQ_W);

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    // R6
    mark_younger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mark_o[i] |-> (valid_i[i] && seq_i[i] > tgt_q));
  end
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core #(
  parameter int DEPTH = 8,
  parameter int SQ_W  = 2,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [PC_W-1:0]  alloc_pc_i,
  input  logic [PC_W-1:0]  alloc_npc_i,
  input  logic [SEQ_W-1:0] alloc_seq_i,
  output logic [IDX_W-1:0] alloc_idx_o,
  output logic             full_o,
  input  logic             cmpl_i,
  input  logic [IDX_W-1:0] cmpl_idx_i,
  input  logic             retire_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             squash_done_o,
  output logic [CNT_W-1:0] free_cnt_o,
  output logic             head_ready_o,
  output logic             head_squashed_o,
  output logic [PC_W-1:0]  head_pc_o,
  output logic [PC_W-1:0]  head_npc_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic [PC_W-1:0]  tail_pc_o,
  output logic [SEQ_W-1:0] tail_seq_o
);
  if ((1 << IDX_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
    $error("rob_core: DEPTH must be a power of two, at least 2");
  end
  if (SQ_W < 1) begin : g_bad_width
    $error("rob_core: SQ_W must be at least 1");
  end

  logic [IDX_W-1:0]            head, wr, tail;
  logic [CNT_W-1:0]            count;
  logic                        alloc_fire, retire_fire, sq_start, empty;
  logic [DEPTH-1:0]            valid, ready, squashed, mark;
  logic [DEPTH-1:0][PC_W-1:0]  pc, npc;
  logic [DEPTH-1:0][SEQ_W-1:0] seq;

  assign empty       = (count == '0);
  assign full_o      = (count == CNT_W'(DEPTH));
  assign alloc_fire  = alloc_i && !full_o && squash_done_o && !squash_i;
  assign head_ready_o = !empty && ready[head];
  assign retire_fire = retire_i && head_ready_o;
  assign sq_start    = squash_i && squash_done_o && !empty;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_fire_i  (alloc_fire),
    .retire_fire_i (retire_fire),
    .head_o        (head),
    .wr_o          (wr),
    .tail_o        (tail),
    .count_o       (count)
  );

  rob_store #(.DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_we_i  (alloc_fire),
    .alloc_idx_i (wr),
    .alloc_pc_i  (alloc_pc_i),
    .alloc_npc_i (alloc_npc_i),
    .alloc_seq_i (alloc_seq_i),
    .cmpl_we_i   (cmpl_i),
    .cmpl_idx_i  (cmpl_idx_i),
    .ret_we_i    (retire_fire),
    .ret_idx_i   (head),
    .mark_i      (mark),
    .valid_o     (valid),
    .ready_o     (ready),
    .squashed_o  (squashed),
    .pc_o        (pc),
    .npc_o       (npc),
    .seq_o       (seq)
  );

  rob_squash_walk #(.DEPTH(DEPTH), .SQ_W(SQ_W), .SEQ_W(SEQ_W)) i_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sq_start),
    .tgt_i   (squash_seq_i),
    .tail_i  (tail),
    .head_i  (head),
    .valid_i (valid),
    .seq_i   (seq),
    .mark_o  (mark),
    .done_o  (squash_done_o)
  );

  assign alloc_idx_o     = wr;
  assign free_cnt_o      = CNT_W'(DEPTH) - count;
  assign head_squashed_o = !empty && squashed[head];
  assign head_pc_o       = pc[head];
  assign head_npc_o      = npc[head];
  assign head_seq_o      = seq[head];
  assign tail_pc_o       = pc[tail];
  assign tail_seq_o      = seq[tail];

  // R5
  empty_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt_o == CNT_W'(DEPTH)) |-> !head_ready_o);
  // R9
  no_alloc_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !squash_done_o |=> (alloc_idx_o == $past(alloc_idx_o)));
  // R4
  retire_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !ready[head]) |=> (free_cnt_o <= $past(free_cnt_o)));
endmodule

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
module test_rob_core;
  localparam int DEPTH = 8;
  localparam int SQ_W  = 2;
  localparam int PC_W  = 32;
  localparam int SEQ_W = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic alloc_i = 0, cmpl_i = 0, retire_i = 0, squash_i = 0;
  logic [PC_W-1:0]  alloc_pc_i = '0, alloc_npc_i = '0;
  logic [SEQ_W-1:0] alloc_seq_i = '0, squash_seq_i = '0;
  logic [IDX_W-1:0] cmpl_idx_i = '0;
  logic [IDX_W-1:0] alloc_idx_o;
  logic             full_o, squash_done_o, head_ready_o, head_squashed_o;
  logic [CNT_W-1:0] free_cnt_o;
  logic [PC_W-1:0]  head_pc_o, head_npc_o, tail_pc_o;
  logic [SEQ_W-1:0] head_seq_o, tail_seq_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .SQ_W(SQ_W), .PC_W(PC_W), .SEQ_W(SEQ_W)) i_rob_core (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_i(alloc_i), .alloc_pc_i(alloc_pc_i), .alloc_npc_i(alloc_npc_i),
    .alloc_seq_i(alloc_seq_i), .alloc_idx_o(alloc_idx_o), .full_o(full_o),
    .cmpl_i(cmpl_i), .cmpl_idx_i(cmpl_idx_i), .retire_i(retire_i),
    .squash_i(squash_i), .squash_seq_i(squash_seq_i), .squash_done_o(squash_done_o),
    .free_cnt_o(free_cnt_o), .head_ready_o(head_ready_o), .head_squashed_o(head_squashed_o),
    .head_pc_o(head_pc_o), .head_npc_o(head_npc_o), .head_seq_o(head_seq_o),
    .tail_pc_o(tail_pc_o), .tail_seq_o(tail_seq_o)
  );

  typedef struct packed {
    logic [1:0] op;      // 0 alloc seq=arg, 1 complete slot=arg, 2 retire
    logic [7:0] arg;
    logic [3:0] e_free;
    logic       e_rdy;
    logic [7:0] e_head;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd0, 8'd1, 4'd7, 1'b0, 8'd1},
    '{2'd0, 8'd2, 4'd6, 1'b0, 8'd1},
    '{2'd0, 8'd3, 4'd5, 1'b0, 8'd1},
    '{2'd0, 8'd4, 4'd4, 1'b0, 8'd1},
    '{2'd2, 8'd0, 4'd4, 1'b0, 8'd1},
    '{2'd1, 8'd0, 4'd4, 1'b1, 8'd1},
    '{2'd1, 8'd2, 4'd4, 1'b1, 8'd1},
    '{2'd2, 8'd0, 4'd5, 1'b0, 8'd2},
    '{2'd1, 8'd1, 4'd5, 1'b1, 8'd2},
    '{2'd2, 8'd0, 4'd6, 1'b1, 8'd3},
    '{2'd2, 8'd0, 4'd7, 1'b0, 8'd4},
    '{2'd2, 8'd0, 4'd7, 1'b0, 8'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    alloc_i = 0; cmpl_i = 0; retire_i = 0; squash_i = 0;
  endtask

  task automatic do_alloc(input int s);
    alloc_i = 1; alloc_seq_i = SEQ_W'(s);
    alloc_pc_i = PC_W'(32'h1000 + s * 4); alloc_npc_i = PC_W'(32'h1004 + s * 4);
    step();
  endtask

  task automatic do_cmpl(input int idx);
    cmpl_i = 1; cmpl_idx_i = IDX_W'(idx); step();
  endtask

  task automatic do_retire();
    retire_i = 1; step();
  endtask

  task automatic do_squash(input int s);
    squash_i = 1; squash_seq_i = SEQ_W'(s); step();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    #5;
    // R1 / R5: reset state
    chk("R1 free", 32'(free_cnt_o), DEPTH);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 done", 32'(squash_done_o), 1);
    chk("R5 ready empty", 32'(head_ready_o), 0);
    @(negedge clk); rst_ni = 1; #1;

    // Table: allocate, complete, retire
    for (int v = 0; v < 12; v++) begin
      case (VEC[v].op)
        2'd0: do_alloc(int'(VEC[v].arg));
        2'd1: do_cmpl(int'(VEC[v].arg));
        default: do_retire();
      endcase
      chk("R3 vec free", 32'(free_cnt_o), 32'(VEC[v].e_free));
      chk("R4 R10 vec ready", 32'(head_ready_o), 32'(VEC[v].e_rdy));
      chk("R2 vec head seq", 32'(head_seq_o), 32'(VEC[v].e_head));
    end
    chk("R2 head pc", head_pc_o, 32'h1000 + 4 * 4);
    chk("R2 head npc", head_npc_o, 32'h1004 + 4 * 4);

    // Fill to full, wrapping
    for (int s = 5; s <= 11; s++) do_alloc(s);
    chk("R2 full", 32'(full_o), 1);
    chk("R3 free full", 32'(free_cnt_o), 0);
    do_alloc(99);
    chk("R2 alloc full ignored", 32'(tail_seq_o), 11);
    chk("R2 tail pc", tail_pc_o, 32'h1000 + 11 * 4);

    // Squash to seq 6: five younger, W=2 -> three walk edges
    do_squash(6);
    chk("R6 done low", 32'(squash_done_o), 0);
    step(); chk("R7 walk 1", 32'(squash_done_o), 0);
    step(); chk("R7 walk 2", 32'(squash_done_o), 0);
    step(); chk("R7 walk 3 done", 32'(squash_done_o), 1);

    do_cmpl(3); do_retire();
    do_cmpl(4); do_retire();
    chk("R7 target head", 32'(head_seq_o), 6);
    chk("R7 target not ready", 32'(head_ready_o), 0);
    chk("R7 target not squashed", 32'(head_squashed_o), 0);
    do_cmpl(5); do_retire();
    chk("R6 squashed head seq", 32'(head_seq_o), 7);
    chk("R6 squashed ready", 32'(head_ready_o), 1);
    chk("R6 squashed flag", 32'(head_squashed_o), 1);
    for (int r = 0; r < 5; r++) do_retire();
    chk("R3 drained free", 32'(free_cnt_o), DEPTH);
    chk("R5 empty ready", 32'(head_ready_o), 0);

    // Retire during walk, alloc blocked (slots 3,4,5)
    do_alloc(20); do_alloc(21); do_alloc(22);
    do_cmpl(3);
    alloc_i = 1; alloc_seq_i = 16'd29;
    squash_i = 1; squash_seq_i = 16'd5; step();
    chk("R6 done low 2", 32'(squash_done_o), 0);
    chk("R9 alloc same cycle ignored", 32'(tail_seq_o), 22);
    retire_i = 1; alloc_i = 1; alloc_seq_i = 16'd30; step();
    chk("R9 retire during walk", 32'(free_cnt_o), 6);
    step();
    chk("R9 walk ends at retired slot", 32'(squash_done_o), 1);
    chk("R9 alloc ignored tail", 32'(tail_seq_o), 22);
    chk("R6 head squashed 21", 32'(head_squashed_o), 1);
    do_retire(); do_retire();
    chk("R4 empty again", 32'(free_cnt_o), DEPTH);

    // Head reach: target absent (slots 6,7,0)
    do_alloc(40); do_alloc(41); do_alloc(42);
    do_squash(1);
    step(); chk("R8 walk 1", 32'(squash_done_o), 0);
    step(); chk("R8 done at head", 32'(squash_done_o), 1);
    chk("R8 head squashed", 32'(head_squashed_o), 1);
    chk("R8 head ready", 32'(head_ready_o), 1);
    for (int r = 0; r < 3; r++) do_retire();
    chk("R3 free after head reach", 32'(free_cnt_o), DEPTH);

    // Squash on empty buffer is ignored
    do_squash(3);
    chk("R6 empty squash ignored", 32'(squash_done_o), 1);
    do_retire();
    chk("R4 retire empty ignored", 32'(free_cnt_o), DEPTH);

    summary();
  end
endmodule